// File: doc/BRIEF.md
# PHY Basic Control and Status Registers

This block is the management register pair of an Ethernet physical-layer device. Address 0 is a control register and address 1 is a read-only status register. Both are reached through a simple parallel register port with a 5-bit address, 16-bit write data, single-cycle write and read strobes, and registered 16-bit read data. The serial management framing in front of it and the negotiation engine behind it are separate blocks.

Strap inputs give the reset values of the negotiation-enable, speed and duplex fields. The control register drives the power-down, isolate, negotiation-enable, negotiation-restart, speed and duplex outputs. Its write rules are not uniform. Speed and duplex accept new values only while negotiation is off. The restart request is accepted only while negotiation is on, and it clears itself when the negotiation engine reports a start. A software reset bit reloads every default, including fresh strap values.

A collision-test path generates a COL indication from the transmit enable. It is timed in bit times by a bit-time enable pulse. Isolate and power-down both silence this path and make it ignore the transmit enable.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While reset is low, and after it rises, the outputs are: power-down 0, isolate 0, restart 0, collision test off, and negotiation-enable, speed and duplex equal to the strap inputs.
- R2: A read of address 1 returns 0x6000. Bit 15 (four-pair 100 Mb capability) is 0, bits 14 and 13 (100 Mb full- and half-duplex capability) are 1, and all other bits are 0. Writes to address 1 change nothing.
- R3: A write to address 0 stores bit 12 (negotiation enable), bit 11 (power-down), bit 10 (isolate) and bit 7 (collision test). The new values appear on the outputs and in read-back on the cycle after the write.
- R4: Bits 13 (speed low), 6 (speed high) and 8 (duplex, 1 = full) of a write to address 0 are stored only if negotiation was disabled before that write. Otherwise they keep their previous values.
- R5: Writing 1 to bit 9 of address 0 sets the restart request only if negotiation was enabled before the write. The request then reads as 1 until the cycle after `an_started` is seen high. Writing 0 to bit 9 does not clear it.
- R6: Writing 1 to bit 15 of address 0 restores every control field to its reset value, using the strap values present at the write. Bit 15 then reads 1 for exactly one cycle, and all other bits of that write are ignored.
- R7: Bits 14 and 5:0 of address 0 always read 0, and writes to them have no effect.
- R8: Any address other than 0 and 1 reads 0, and writes to it change nothing.
- R9: `reg_rdata` holds the register value from before the strobe edge, one cycle after `reg_rd`. This includes a write in the same cycle. In every cycle without a read strobe it is 0.
- R10: With collision test on, `col_o` rises on the first bit-time pulse after `tx_en` goes high. It falls on the third bit-time pulse after `tx_en` goes low. A change of `tx_en` that reverts before completing its count leaves `col_o` unchanged.
- R11: With collision test off, or with isolate or power-down set, `col_o` is 0 on the cycle after, and `tx_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| strap_an_en | input | 1 | Reset value of negotiation enable |
| strap_speed | input | 2 | Reset value of speed {high, low} |
| strap_duplex | input | 1 | Reset value of duplex |
| an_started | input | 1 | Negotiation engine has begun a new round |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmit enable |
| pdn_o | output | 1 | Power-down |
| iso_o | output | 1 | Isolate |
| an_en_o | output | 1 | Negotiation enable |
| an_restart_o | output | 1 | Negotiation restart request |
| speed_o | output | 2 | Speed select {high, low} |
| duplex_o | output | 1 | Duplex, 1 = full |
| col_o | output | 1 | Collision-test COL indication |

## Verification
Every control output and `reg_rdata` comes from a single register stage. A write, a read strobe or an `an_started` pulse therefore shows its result exactly one clock after the edge that samples it. A reference model in the bench advances on that same rising edge using only the port inputs. Each result is compared at the following falling edge, so no result can be matched a cycle early or late. The collision output is due a number of clock cycles set by the spacing of `bit_tick` pulses, and the model counts those pulses rather than clocks.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int REG_DW    = 16;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;

  // control register bit positions
  localparam int B_SRST   = 15;
  localparam int B_SPD_LO = 13;
  localparam int B_ANEN   = 12;
  localparam int B_PDN    = 11;
  localparam int B_ISO    = 10;
  localparam int B_RSTRT  = 9;
  localparam int B_DPLX   = 8;
  localparam int B_CTEST  = 7;
  localparam int B_SPD_HI = 6;

  // status register capability bits
  localparam int B_CAP_T4  = 15;
  localparam int B_CAP_XFD = 14;
  localparam int B_CAP_XHD = 13;

  typedef struct packed {
    logic       srst;
    logic [1:0] speed;   // {high, low}
    logic       an_en;
    logic       pdn;
    logic       iso;
    logic       restart;
    logic       duplex;
    logic       ctest;
  } ctrl_t;

  function automatic logic [REG_DW-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_DW-1:0] w;
    w           = '0;
    w[B_SRST]   = c.srst;
    w[B_SPD_LO] = c.speed[0];
    w[B_ANEN]   = c.an_en;
    w[B_PDN]    = c.pdn;
    w[B_ISO]    = c.iso;
    w[B_RSTRT]  = c.restart;
    w[B_DPLX]   = c.duplex;
    w[B_CTEST]  = c.ctest;
    w[B_SPD_HI] = c.speed[1];
    return w;
  endfunction

  function automatic logic [REG_DW-1:0] status_word();
    logic [REG_DW-1:0] w;
    w            = '0;
    w[B_CAP_T4]  = 1'b0;
    w[B_CAP_XFD] = 1'b1;
    w[B_CAP_XHD] = 1'b1;
    return w;
  endfunction

  function automatic ctrl_t ctrl_default(input logic an, input logic [1:0] spd,
                                         input logic dpx);
    ctrl_t c;
    c         = '0;
    c.an_en   = an;
    c.speed   = spd;
    c.duplex  = dpx;
    return c;
  endfunction

endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_DW-1:0] wdata,
  input  logic              an_started,
  input  logic              strap_an_en,
  input  logic [1:0]        strap_speed,
  input  logic              strap_duplex,
  output ctrl_t             ctrl,
  output logic              soft_rst_evt,
  output logic              restart_set_evt,
  output logic              restart_clr_evt
);

  ctrl_t nxt;
  logic  unused_wbits;

  assign unused_wbits    = ^{wdata[14], wdata[5:0]};
  assign soft_rst_evt    = wr_en & wdata[B_SRST];
  assign restart_set_evt = wr_en & ~wdata[B_SRST] & wdata[B_RSTRT] & ctrl.an_en;
  assign restart_clr_evt = an_started & ctrl.restart;

  always_comb begin
    nxt      = ctrl;
    nxt.srst = 1'b0;
    if (restart_clr_evt) nxt.restart = 1'b0;
    if (soft_rst_evt) begin
      nxt      = ctrl_default(strap_an_en, strap_speed, strap_duplex);
      nxt.srst = 1'b1;
    end else if (wr_en) begin
      nxt.an_en = wdata[B_ANEN];
      nxt.pdn   = wdata[B_PDN];
      nxt.iso   = wdata[B_ISO];
      nxt.ctest = wdata[B_CTEST];
      if (!ctrl.an_en) begin
        nxt.speed  = {wdata[B_SPD_HI], wdata[B_SPD_LO]};
        nxt.duplex = wdata[B_DPLX];
      end
      if (restart_set_evt) nxt.restart = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= ctrl_default(strap_an_en, strap_speed, strap_duplex);
    else        ctrl <= nxt;
  end

endmodule

// File: rtl/phy_col_test.sv
module phy_col_test #(
  parameter int ON_TICKS  = 1,
  parameter int OFF_TICKS = 3
)(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tx_en,
  input  logic bit_tick,
  output logic col,
  output logic col_change_evt
);

  localparam int MAX_TICKS = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  function automatic logic [CNT_W-1:0] ticks_needed(input logic rising);
    return rising ? CNT_W'(ON_TICKS) : CNT_W'(OFF_TICKS);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             pending;

  assign pending        = tx_en ^ col;
  assign col_change_evt = enable & pending & bit_tick &
                          ((cnt + 1'b1) == ticks_needed(tx_en));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      col <= 1'b0;
      cnt <= '0;
    end else if (!pending) begin
      cnt <= '0;
    end else if (col_change_evt) begin
      col <= tx_en;
      cnt <= '0;
    end else if (bit_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/phy_rd_port.sv
module phy_rd_port
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_DW-1:0] ctrl_word,
  output logic [REG_DW-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic [REG_DW-1:0] sel;

  always_comb begin
    if (addr == A_CTRL)      sel = ctrl_word;
    else if (addr == A_STAT) sel = status_word();
    else                     sel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
    else            rdata <= '0;
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int COL_ON_TICKS  = 1,
  parameter int COL_OFF_TICKS = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              strap_an_en,
  input  logic [1:0]        strap_speed,
  input  logic              strap_duplex,
  input  logic              an_started,
  input  logic              bit_tick,
  input  logic              tx_en,
  output logic              pdn_o,
  output logic              iso_o,
  output logic              an_en_o,
  output logic              an_restart_o,
  output logic [1:0]        speed_o,
  output logic              duplex_o,
  output logic              col_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

  ctrl_t             ctrl;
  logic              wr_ctrl;
  logic              soft_rst_evt;
  logic              restart_set_evt;
  logic              restart_clr_evt;
  logic              col_enable;
  logic              tx_en_eff;
  logic              col_change_evt;
  logic [REG_DW-1:0] ctrl_word;

  assign wr_ctrl    = reg_wr & (reg_addr == A_CTRL);
  assign ctrl_word  = pack_ctrl(ctrl);
  assign col_enable = ctrl.ctest & ~ctrl.iso & ~ctrl.pdn;
  assign tx_en_eff  = tx_en & ~ctrl.iso & ~ctrl.pdn;

  phy_ctrl_reg u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_ctrl),
    .wdata           (reg_wdata),
    .an_started      (an_started),
    .strap_an_en     (strap_an_en),
    .strap_speed     (strap_speed),
    .strap_duplex    (strap_duplex),
    .ctrl            (ctrl),
    .soft_rst_evt    (soft_rst_evt),
    .restart_set_evt (restart_set_evt),
    .restart_clr_evt (restart_clr_evt)
  );

  phy_col_test #(
    .ON_TICKS  (COL_ON_TICKS),
    .OFF_TICKS (COL_OFF_TICKS)
  ) u_col (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (col_enable),
    .tx_en          (tx_en_eff),
    .bit_tick       (bit_tick),
    .col            (col_o),
    .col_change_evt (col_change_evt)
  );

  phy_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd),
    .addr      (reg_addr),
    .ctrl_word (ctrl_word),
    .rdata     (reg_rdata)
  );

  assign pdn_o        = ctrl.pdn;
  assign iso_o        = ctrl.iso;
  assign an_en_o      = ctrl.an_en;
  assign an_restart_o = ctrl.restart;
  assign speed_o      = ctrl.speed;
  assign duplex_o     = ctrl.duplex;

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int ADDR_W = 5
)(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [15:0]       reg_rdata,
  input logic              an_started,
  input logic              pdn_o,
  input logic              iso_o,
  input logic              an_en_o,
  input logic              an_restart_o,
  input logic [1:0]        speed_o,
  input logic              duplex_o,
  input logic              col_o,
  input logic              soft_rst_evt
);

  assert_speed_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (an_en_o && !soft_rst_evt) |=> ($stable(speed_o) && $stable(duplex_o)));

  assert_restart_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!an_en_o && !an_restart_o) |=> !an_restart_o);

  assert_restart_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (an_restart_o && !an_started && !soft_rst_evt) |=> an_restart_o);

  assert_soft_rst_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_evt |=> (!pdn_o && !iso_o && !an_restart_o));

  assert_status_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(1)) |=> (reg_rdata == 16'h6000));

  assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr > ADDR_W'(1)) |=> (reg_rdata == 16'h0000));

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == 16'h0000));

  assert_col_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_o || pdn_o) |=> !col_o);

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_rd       (reg_rd),
  .reg_rdata    (reg_rdata),
  .an_started   (an_started),
  .pdn_o        (pdn_o),
  .iso_o        (iso_o),
  .an_en_o      (an_en_o),
  .an_restart_o (an_restart_o),
  .speed_o      (speed_o),
  .duplex_o     (duplex_o),
  .col_o        (col_o),
  .soft_rst_evt (soft_rst_evt)
);

// File: tb/sim_phy_mgmt_regs.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        strap_an_en = 1'b1;
  logic [1:0]  strap_speed = 2'b10;
  logic        strap_duplex = 1'b1;
  logic        an_started = 1'b0, bit_tick = 1'b0, tx_en = 1'b0;
  logic        pdn_o, iso_o, an_en_o, an_restart_o, duplex_o, col_o;
  logic [1:0]  speed_o;

  always #2 clk = ~clk;   // 250 MHz

  phy_mgmt_regs u0 (.*);

  int    vectors = 0, miscmp = 0, cycles = 0;
  string phase = "R1";
  bit    model_live = 0, tick_run = 0;
  int    tick_div = 0;

  // behavioural reference state
  int m_srst, m_an, m_pd, m_iso, m_rs, m_dpx, m_ct, m_spd, m_col, m_cnt, m_rdata;

  function automatic int ctrl_value();
    return m_srst * 32768 + (m_spd % 2) * 8192 + m_an * 4096 + m_pd * 2048 +
           m_iso * 1024 + m_rs * 512 + m_dpx * 256 + m_ct * 128 + (m_spd / 2) * 64;
  endfunction

  function automatic int bitof(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  task automatic load_defaults();
    m_an = strap_an_en; m_spd = strap_speed; m_dpx = strap_duplex;
    m_pd = 0; m_iso = 0; m_rs = 0; m_ct = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      load_defaults(); m_srst = 0; m_rdata = 0; m_col = 0; m_cnt = 0;
    end else begin
      int wd, old_an;
      wd = reg_wdata;
      if (!reg_rd)             m_rdata = 0;
      else if (reg_addr == 0)  m_rdata = ctrl_value();
      else if (reg_addr == 1)  m_rdata = 24576;
      else                     m_rdata = 0;
      // collision test, judged on the state before this edge
      if (m_ct == 0 || m_iso == 1 || m_pd == 1) begin
        m_col = 0; m_cnt = 0;
      end else if (int'(tx_en) != m_col) begin
        if (bit_tick) begin
          m_cnt = m_cnt + 1;
          if (m_cnt >= (tx_en ? 1 : 3)) begin m_col = tx_en; m_cnt = 0; end
        end
      end else m_cnt = 0;
      m_srst = 0;
      if (an_started) m_rs = 0;
      if (reg_wr && reg_addr == 0) begin
        if (bitof(wd, 15) == 1) begin
          load_defaults(); m_srst = 1;
        end else begin
          old_an = m_an;
          m_an = bitof(wd, 12); m_pd = bitof(wd, 11);
          m_iso = bitof(wd, 10); m_ct = bitof(wd, 7);
          if (old_an == 0) begin
            m_spd = bitof(wd, 6) * 2 + bitof(wd, 13);
            m_dpx = bitof(wd, 8);
          end
          if (old_an == 1 && bitof(wd, 9) == 1) m_rs = 1;
        end
      end
    end
    model_live = 1;
  end

  task automatic chk(input string sig, input int act, input int exp);
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, sig, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_live) begin
      vectors++;
      chk("pdn_o", pdn_o, m_pd);
      chk("iso_o", iso_o, m_iso);
      chk("an_en_o", an_en_o, m_an);
      chk("an_restart_o", an_restart_o, m_rs);
      chk("speed_o", speed_o, m_spd);
      chk("duplex_o", duplex_o, m_dpx);
      chk("col_o", col_o, m_col);
      chk("reg_rdata", reg_rdata, m_rdata);
    end
    if (tick_run) begin
      tick_div = (tick_div + 1) % 4;
      bit_tick = (tick_div == 0);
    end else bit_tick = 1'b0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscmp++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 5'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk); reg_addr = 5'(a); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rw(input int a, input int d);
    @(negedge clk); reg_addr = 5'(a); reg_wdata = 16'(d); reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  initial begin
    phase = "R1";                         // strap defaults in and after reset
    idle(4); rst_n = 1'b1; idle(2); rd(0);
    phase = "R2";                         // status constant, writes ignored
    rd(1); wr(1, 16'h0000); rd(1); rd(0);
    phase = "R4";                         // speed/duplex locked while negotiation on
    wr(0, 16'h1000); rd(0);
    wr(0, 16'h0000);                      // negotiation off, speed still locked this write
    wr(0, 16'h2000); rd(0);               // speed low=1, duplex half
    wr(0, 16'h0140); rd(0);               // speed high=1, duplex full
    phase = "R5";                         // restart gated by negotiation enable
    wr(0, 16'h0200); rd(0);
    wr(0, 16'h1200); rd(0);               // enables, restart still ignored
    wr(0, 16'h1200); rd(0);               // now accepted
    wr(0, 16'h1000); idle(2); rd(0);      // writing 0 keeps it
    @(negedge clk); an_started = 1'b1; @(negedge clk); an_started = 1'b0; rd(0);
    @(negedge clk); an_started = 1'b1; @(negedge clk); an_started = 1'b0; rd(0);
    phase = "R3";                         // plain fields
    wr(0, 16'h0800); rd(0); wr(0, 16'h0400); rd(0);
    wr(0, 16'h0C80); rd(0); wr(0, 16'h0000); rd(0);
    phase = "R7";                         // reserved bits
    wr(0, 16'h403F); rd(0); wr(0, 16'h7FFF); rd(0);
    phase = "R8";                         // unimplemented addresses
    wr(0, 16'h0000);
    wr(7, 16'hFFFF); wr(31, 16'hFFFF); rd(7); rd(31); rd(2); rd(0);
    phase = "R9";                         // read with same-cycle write sees old value
    rw(0, 16'h0C00); rd(0); rw(0, 16'h0000); idle(2);
    phase = "R10";                        // collision test timing
    tick_run = 1; wr(0, 16'h0080);
    @(negedge clk); tx_en = 1'b1; idle(20);
    @(negedge clk); tx_en = 1'b0; idle(30);
    @(negedge clk); tx_en = 1'b1; idle(20);
    @(negedge clk); tx_en = 1'b0; idle(5);
    @(negedge clk); tx_en = 1'b1; idle(12);
    @(negedge clk); tx_en = 1'b0; idle(30);
    phase = "R11";                        // silenced by off, isolate, power-down
    @(negedge clk); tx_en = 1'b1; idle(12);
    wr(0, 16'h0480); idle(20);
    wr(0, 16'h0080); idle(12);
    wr(0, 16'h0880); idle(20);
    wr(0, 16'h0000); idle(20);
    @(negedge clk); tx_en = 1'b0; idle(4);
    phase = "R6";                         // software reset with new straps
    strap_an_en = 1'b0; strap_speed = 2'b01; strap_duplex = 1'b0;
    wr(0, 16'h1E80);
    wr(0, 16'hFFFF); rd(0); rd(0);
    strap_an_en = 1'b1; strap_speed = 2'b11;
    wr(0, 16'h8000); rd(0); idle(3);
    tick_run = 0; idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule